// File: doc/BRIEF.md
# Infrared Link Byte Buffer with Tagged Receive Queue

This block sits between a host register port and the byte side of a serial infrared link. It holds a transmit queue and a receive queue, each `DEPTH` entries of one byte. Every receive entry also carries two tag bits: end of frame and error. One data address serves both queues. A host write to it appends a byte to the transmit queue, and a host read from it takes the oldest byte out of the receive queue. The line side takes transmit bytes with a pop strobe and delivers receive bytes, with their tags, through a push strobe.

A status word collects the block's events. Hardware sets the sticky bits for transmit underrun, receiver abort and framing error, and software clears each one by writing 1 to it. The read-only flags are the two service requests, the tag-window flag, the queue flags and the tags of the oldest receive entry. Each event drives the interrupt output for as long as it is present. Three of the events also have enable bits in the control word.

The two service requests also serve as DMA request outputs. The tag-window flag is set when any of the oldest `TAG_WIN` receive entries carries a tag, and while it is set the receive DMA request stays low. Software then reads entries one at a time and checks the flag after each read. Receive DMA starts again by itself once the flag clears.

Top module: `irbuf_top`

## Requirements
- R1: After reset both queues are empty, the control word (address 0) reads 0, the status word (address 2) reads 0, and `tx_valid`, `tx_dma_req`, `rx_dma_req` and `irq` are all low.
- R2: A host write to address 1 appends `wdata[7:0]` to the transmit queue, and the line side sees the bytes on `tx_data`/`tx_valid` in the order they were written. A host read of address 1 returns `{22'b0, err, eof, byte}` of the oldest receive entry and removes that entry. Bits [31:10] are zero, and the read returns 0 when the receive queue is empty.
- R3: The control word has transmit enable at bit 0 and receive enable at bit 1. While an enable bit is 0, its queue is flushed and held empty, and pushes into it are ignored.
- R4: A push into a full queue is dropped, and the entries already held are unchanged.
- R5: `tx_dma_req` (status bit 0) is 1 exactly when transmit is enabled and the number of free transmit entries is at least `DEPTH/2`.
- R6: `rx_dma_req` (status bit 1) is 1 exactly when receive is enabled, the receive queue holds at least `DEPTH/2` entries and the tag-window flag is 0.
- R7: The tag-window flag (status bit 5) is 1 exactly when at least one of the oldest min(`TAG_WIN`, count) receive entries has its eof or err tag set.
- R8: Transmit underrun (status bit 3) is set when `tx_pop` arrives while transmit is enabled and the transmit queue is empty. It stays set until the host writes 1 to bit 3 of address 2. Writing 0 to the bit leaves it unchanged, and a new event in the same cycle as the clearing write wins.
- R9: Receiver abort (status bit 2) and framing error (status bit 4) are set by the `rx_abort` and `rx_frame_err` pulses. Each is cleared by writing 1 to its own bit and keeps its value when 0 is written.
- R10: Writes to the read-only status bits (0, 1, 5, 6, 7, 8, 9) have no effect. Bit 6 is "receive queue not empty", bit 7 is "transmit queue full", and bits 8 and 9 are the eof and err tags of the oldest receive entry (0 when the queue is empty).
- R11: `irq` is the OR of: abort, framing error, tag-window flag, underrun AND control bit 4, transmit request AND control bit 2, and receive request AND control bit 3. A masked event still shows in the status word.
- R12: When the queues are enabled, a host read of address 1 and a line-side push in the same cycle both take effect, and so do a host write of address 1 and a line-side pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a read of address 1 removes an entry) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from `host_addr` |
| tx_pop | input | 1 | Line side takes the oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Line side delivers a receive byte |
| rx_byte | input | 8 | Receive byte |
| rx_eof | input | 1 | End-of-frame tag for the pushed byte |
| rx_err | input | 1 | Error tag for the pushed byte |
| rx_abort | input | 1 | Receiver abort event pulse |
| rx_frame_err | input | 1 | Framing error event pulse |
| tx_dma_req | output | 1 | Transmit DMA service request |
| rx_dma_req | output | 1 | Receive DMA service request |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults, `DEPTH=8` and `TAG_WIN=4`. These are small enough that random push and pop traffic often reaches both the full and the empty ends of each queue, and crosses the half-depth thresholds of the service requests many times. A four-entry window against eight entries makes two cases common. In one, a tagged entry sits just behind the window while the receive request would otherwise be high. In the other, draining one entry brings a deeper tag into the window.

// File: rtl/irbuf_pkg.sv
package irbuf_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int ST_TXREQ  = 0;
  localparam int ST_RXREQ  = 1;
  localparam int ST_ABORT  = 2;
  localparam int ST_UNDER  = 3;
  localparam int ST_FRAME  = 4;
  localparam int ST_TAGWIN = 5;
  localparam int ST_RXNE   = 6;
  localparam int ST_TXFULL = 7;
  localparam int ST_HDEOF  = 8;
  localparam int ST_HDERR  = 9;
  localparam int ST_W      = 10;

  localparam int RXE_W = 10;

  typedef struct packed {
    logic ie_under;
    logic ie_rx;
    logic ie_tx;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  function automatic logic has_half_free(input int count, input int depth);
    return (depth - count) >= (depth / 2);
  endfunction

  function automatic logic has_half_full(input int count, input int depth);
    return count >= (depth / 2);
  endfunction

  function automatic logic sticky_next(input logic cur, input logic set_evt,
                                       input logic clr_req);
    return set_evt | (cur & ~clr_req);
  endfunction

endpackage

// File: rtl/irbuf_fifo.sv
module irbuf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int PEEK  = 1,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [CW-1:0]            count,
  output logic [PEEK-1:0][W-1:0]   peek,
  output logic                     push_ok,
  output logic                     pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int k);
    int s;
    s = (int'(p) + k) % DEPTH;
    return PW'(s);
  endfunction

  assign push_ok = push && !clr && (int'(cnt_q) < DEPTH);
  assign pop_ok  = pop  && !clr && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wrap_add(wr_q, 1);
      if (pop_ok)  rd_q <= wrap_add(rd_q, 1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  generate
    for (genvar i = 0; i < PEEK; i++) begin : g_peek
      assign peek[i] = mem[wrap_add(rd_q, i)];
    end
  endgenerate

endmodule

// File: rtl/irbuf_tagscan.sv
module irbuf_tagscan #(
  parameter int W       = 10,
  parameter int DEPTH   = 8,
  parameter int TAG_WIN = 4,
  parameter int TAG_LSB = 8,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic [TAG_WIN-1:0][W-1:0] peek,
  input  logic [CW-1:0]             count,
  output logic                      tag_hit
);

  logic [TAG_WIN-1:0] slot_hit;

  function automatic logic entry_tagged(input logic [W-1:0] e);
    return |e[W-1:TAG_LSB];
  endfunction

  generate
    for (genvar i = 0; i < TAG_WIN; i++) begin : g_slot
      assign slot_hit[i] = (int'(count) > i) && entry_tagged(peek[i]);
    end
  endgenerate

  assign tag_hit = |slot_hit;

endmodule

// File: rtl/irbuf_status.sv
module irbuf_status
  import irbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  input  logic             tag_hit,
  input  logic             head_eof,
  input  logic             head_err,
  input  logic             under_evt,
  input  logic             abort_evt,
  input  logic             frame_evt,
  input  logic             clr_under,
  input  logic             clr_abort,
  input  logic             clr_frame,
  output logic [ST_W-1:0]  stat,
  output logic             tx_req,
  output logic             rx_req,
  output logic             irq
);

  logic under_q, abort_q, frame_q;
  logic rx_ne, tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      under_q <= 1'b0;
      abort_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      under_q <= sticky_next(under_q, under_evt, clr_under);
      abort_q <= sticky_next(abort_q, abort_evt, clr_abort);
      frame_q <= sticky_next(frame_q, frame_evt, clr_frame);
    end
  end

  assign tx_req  = ctrl.tx_en && has_half_free(int'(tx_cnt), DEPTH);
  assign rx_req  = ctrl.rx_en && has_half_full(int'(rx_cnt), DEPTH) && !tag_hit;
  assign rx_ne   = (rx_cnt != '0);
  assign tx_full = (int'(tx_cnt) == DEPTH);

  always_comb begin
    stat            = '0;
    stat[ST_TXREQ]  = tx_req;
    stat[ST_RXREQ]  = rx_req;
    stat[ST_ABORT]  = abort_q;
    stat[ST_UNDER]  = under_q;
    stat[ST_FRAME]  = frame_q;
    stat[ST_TAGWIN] = tag_hit;
    stat[ST_RXNE]   = rx_ne;
    stat[ST_TXFULL] = tx_full;
    stat[ST_HDEOF]  = rx_ne && head_eof;
    stat[ST_HDERR]  = rx_ne && head_err;
  end

  assign irq = abort_q | frame_q | tag_hit
             | (under_q & ctrl.ie_under)
             | (tx_req  & ctrl.ie_tx)
             | (rx_req  & ctrl.ie_rx);

endmodule

// File: rtl/irbuf_top.sv
module irbuf_top
  import irbuf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TAG_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        tx_pop,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic        rx_abort,
  input  logic        rx_frame_err,
  output logic        tx_dma_req,
  output logic        rx_dma_req,
  output logic        irq
);

  localparam int CW    = $clog2(DEPTH + 1);
  localparam int CTL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;

  logic wr_ctrl, wr_data, wr_stat, rd_data;
  logic under_evt, abort_evt, frame_evt;
  logic clr_under, clr_abort, clr_frame;

  logic [7:0]          tx_head;
  logic [CW-1:0]       tx_cnt;
  logic [0:0][7:0]     tx_peek;
  logic                tx_push_ok, tx_pop_ok;

  logic [RXE_W-1:0]              rx_head;
  logic [CW-1:0]                 rx_cnt;
  logic [TAG_WIN-1:0][RXE_W-1:0] rx_peek;
  logic                          rx_push_ok, rx_pop_ok;

  logic              tag_hit;
  logic [ST_W-1:0]   stat;
  logic              tx_req, rx_req;

  assign wr_ctrl = host_wr && (host_addr == ADDR_CTRL);
  assign wr_data = host_wr && (host_addr == ADDR_DATA);
  assign wr_stat = host_wr && (host_addr == ADDR_STAT);
  assign rd_data = host_rd && (host_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(host_wdata[CTL_W-1:0]);
  end

  assign under_evt = tx_pop && ctrl_q.tx_en && (tx_cnt == '0);
  assign abort_evt = rx_abort;
  assign frame_evt = rx_frame_err;
  assign clr_under = wr_stat && host_wdata[ST_UNDER];
  assign clr_abort = wr_stat && host_wdata[ST_ABORT];
  assign clr_frame = wr_stat && host_wdata[ST_FRAME];

  irbuf_fifo #(.W(8), .DEPTH(DEPTH), .PEEK(1)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(!ctrl_q.tx_en),
    .push(wr_data), .din(host_wdata[7:0]), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .peek(tx_peek),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  irbuf_fifo #(.W(RXE_W), .DEPTH(DEPTH), .PEEK(TAG_WIN)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(!ctrl_q.rx_en),
    .push(rx_push), .din({rx_err, rx_eof, rx_byte}), .pop(rd_data),
    .head(rx_head), .count(rx_cnt), .peek(rx_peek),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  irbuf_tagscan #(.W(RXE_W), .DEPTH(DEPTH), .TAG_WIN(TAG_WIN), .TAG_LSB(8)) u_scan (
    .peek(rx_peek), .count(rx_cnt), .tag_hit(tag_hit)
  );

  irbuf_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tag_hit(tag_hit),
    .head_eof(rx_head[8]), .head_err(rx_head[9]),
    .under_evt(under_evt), .abort_evt(abort_evt), .frame_evt(frame_evt),
    .clr_under(clr_under), .clr_abort(clr_abort), .clr_frame(clr_frame),
    .stat(stat), .tx_req(tx_req), .rx_req(rx_req), .irq(irq)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_CTRL: host_rdata[CTL_W-1:0] = ctrl_q;
      ADDR_DATA: if (rx_cnt != '0) host_rdata[RXE_W-1:0] = rx_head;
      ADDR_STAT: host_rdata[ST_W-1:0] = stat;
      default:   host_rdata = '0;
    endcase
  end

  assign tx_valid   = (tx_cnt != '0);
  assign tx_data    = tx_valid ? tx_head : 8'd0;
  assign tx_dma_req = tx_req;
  assign rx_dma_req = rx_req;

endmodule

// File: rtl/irbuf_chk.sv
module irbuf_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          rx_en,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tag_hit,
  input logic          rx_dma_req,
  input logic          tx_dma_req,
  input logic          under_evt,
  input logic          clr_under,
  input logic          under_st,
  input logic          abort_st,
  input logic          irq,
  input logic          rx_push_ok,
  input logic          rx_pop_ok
);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) <= DEPTH) && (int'(tx_cnt) <= DEPTH));

  // R4
  full_push_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) == DEPTH) |-> !rx_push_ok);

  // R6
  tag_blocks_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_hit |-> !rx_dma_req);

  // R3
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tx_cnt == '0));

  // R3
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rx_cnt == '0));

  // R5
  tx_req_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> tx_en);

  // R8
  under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> under_st);

  // R8
  under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (under_st && !clr_under) |=> under_st);

  // R11
  abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_st |-> irq);

  // R12
  rx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_push_ok && !rx_pop_ok) |=> (rx_cnt == $past(rx_cnt) + 1'b1));

endmodule

bind irbuf_top irbuf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .tx_en(ctrl_q.tx_en), .rx_en(ctrl_q.rx_en),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tag_hit(tag_hit),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
  .under_evt(under_evt), .clr_under(clr_under),
  .under_st(stat[3]), .abort_st(stat[2]), .irq(irq),
  .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok)
);

// File: tb/irbuf_top_tb_top.sv
module irbuf_top_tb_top;

  localparam int DEPTH = 8;
  localparam int WIN   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_pop = 1'b0, tx_valid;
  logic [7:0]  tx_data;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_eof = 1'b0, rx_err = 1'b0, rx_abort = 1'b0, rx_frame_err = 1'b0;
  logic        tx_dma_req, rx_dma_req, irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irbuf_top #(.DEPTH(DEPTH), .TAG_WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_abort(rx_abort), .rx_frame_err(rx_frame_err),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  // reference state
  logic [7:0] m_tx[$];
  logic [9:0] m_rx[$];
  logic [4:0] m_ctrl = '0;
  logic m_under = 0, m_abort = 0, m_frame = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_tag();
    for (int i = 0; i < WIN && i < m_rx.size(); i++)
      if (m_rx[i][9:8] != 2'b00) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic f_txreq();
    return m_ctrl[0] && ((DEPTH - m_tx.size()) * 2 >= DEPTH);
  endfunction

  function automatic logic f_rxreq();
    return m_ctrl[1] && (m_rx.size() * 2 >= DEPTH) && !f_tag();
  endfunction

  function automatic logic [31:0] f_stat();
    logic [31:0] s = '0;
    s[0] = f_txreq();
    s[1] = f_rxreq();
    s[2] = m_abort;
    s[3] = m_under;
    s[4] = m_frame;
    s[5] = f_tag();
    s[6] = m_rx.size() != 0;
    s[7] = m_tx.size() == DEPTH;
    if (m_rx.size() != 0) s[9:8] = m_rx[0][9:8];
    return s;
  endfunction

  function automatic logic f_irq();
    return m_abort | m_frame | f_tag() | (m_under & m_ctrl[4])
         | (f_txreq() & m_ctrl[2]) | (f_rxreq() & m_ctrl[3]);
  endfunction

  function automatic logic [31:0] f_read(input logic [1:0] a);
    case (a)
      2'd0: return {27'd0, m_ctrl};
      2'd1: return (m_rx.size() != 0) ? {22'd0, m_rx[0]} : 32'd0;
      2'd2: return f_stat();
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_outputs();
    check("R2 tx_valid", tx_valid, m_tx.size() != 0);
    if (m_tx.size() != 0) check("R2 tx_data order", tx_data, m_tx[0]);
    check("R5 tx_dma_req", tx_dma_req, f_txreq());
    check("R6 rx_dma_req", rx_dma_req, f_rxreq());
    check("R11 irq", irq, f_irq());
  endtask

  // one host/line cycle, entered and left at a falling edge
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [31:0] wd, input logic txp, input logic rxp,
                     input logic [7:0] rb, input logic eof, input logic err,
                     input logic abt, input logic fe);
    logic under_evt;
    logic tx_en, rx_en;
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
    tx_pop = txp; rx_push = rxp; rx_byte = rb; rx_eof = eof; rx_err = err;
    rx_abort = abt; rx_frame_err = fe;
    #2;
    if (rd) begin
      if (a == 2'd1) check("R2 data read", host_rdata, f_read(a));
      else if (a == 2'd2) check("R7 R8 R9 R10 status read", host_rdata, f_read(a));
      else check("R1 ctrl read", host_rdata, f_read(a));
    end
    tx_en = m_ctrl[0]; rx_en = m_ctrl[1];
    under_evt = txp && tx_en && (m_tx.size() == 0);
    if (!tx_en) m_tx.delete();
    else begin
      int n = m_tx.size();
      if (txp && n != 0) void'(m_tx.pop_front());
      if (wr && a == 2'd1 && n < DEPTH) m_tx.push_back(wd[7:0]);
    end
    if (!rx_en) m_rx.delete();
    else begin
      int n = m_rx.size();
      if (rd && a == 2'd1 && n != 0) void'(m_rx.pop_front());
      if (rxp && n < DEPTH) m_rx.push_back({err, eof, rb});
    end
    m_under = under_evt | (m_under & !(wr && a == 2'd2 && wd[3]));
    m_abort = abt | (m_abort & !(wr && a == 2'd2 && wd[2]));
    m_frame = fe | (m_frame & !(wr && a == 2'd2 && wd[4]));
    if (wr && a == 2'd0) m_ctrl = wd[4:0];
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0; tx_pop = 0; rx_push = 0;
    rx_eof = 0; rx_err = 0; rx_abort = 0; rx_frame_err = 0;
    #1;
    check_outputs();
  endtask

  task automatic idle();
    cyc(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 tx_valid", tx_valid, 0);
    check("R1 tx_dma_req", tx_dma_req, 0);
    check("R1 rx_dma_req", rx_dma_req, 0);
    check("R1 irq", irq, 0);
    cyc(0, 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);

    // R3: disabled queues ignore pushes
    cyc(1, 0, 2'd1, 32'h55, 0, 1, 8'h12, 0, 0, 0, 0);
    check("R3 tx held empty", tx_valid, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);

    // enable all
    cyc(1, 0, 2'd0, 32'h1F, 0, 0, 0, 0, 0, 0, 0);
    // R8 underrun, write 0 no effect, write 1 clears
    cyc(0, 0, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 2'd2, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 write to read-only flags
    cyc(1, 0, 2'd2, 32'h3E3, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8 set and clear in same cycle: set wins
    cyc(1, 0, 2'd2, 32'h8, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 2'd2, 32'h1C, 0, 0, 0, 0, 0, 0, 0);

    // R4: fill tx beyond full
    for (int i = 0; i < DEPTH + 1; i++)
      cyc(1, 0, 2'd1, 32'hA0 + i, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 0, 2'd0, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R4 extra byte dropped", tx_valid, 0);

    // R7/R6: tagged entry behind and inside window
    for (int i = 0; i < WIN; i++)
      cyc(0, 0, 2'd0, 0, 0, 1, 8'h30 + i, 0, 0, 0, 0);
    cyc(0, 0, 2'd0, 0, 0, 1, 8'h3E, 1, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 tag outside window", rx_dma_req, 1);
    // R12 read and push together
    cyc(0, 1, 2'd1, 0, 0, 1, 8'h3F, 0, 1, 0, 0);
    check("R7 tag enters window", rx_dma_req, 0);
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 abort and framing
    cyc(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc(1, 0, 2'd2, 32'h4, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 2'd2, 32'h10, 0, 0, 0, 0, 0, 0, 0);
    idle();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      logic wr = 0, rd = 0;
      logic [1:0] a = 0;
      logic [31:0] wd = $urandom;
      if (r < 30) begin wr = 1; a = 2'd1; end
      else if (r < 52) begin rd = 1; a = 2'd1; end
      else if (r < 60) begin rd = 1; a = 2'd2; end
      else if (r < 64) begin wr = 1; a = 2'd2; end
      else if (r < 67) begin
        wr = 1; a = 2'd0;
        wd[0] = ($urandom % 10) != 0;
        wd[1] = ($urandom % 10) != 0;
      end else if (r < 69) begin rd = 1; a = 2'd0; end
      cyc(wr, rd, a, wd, ($urandom % 4) == 0, ($urandom % 3) == 0,
          8'($urandom), ($urandom % 8) == 0, ($urandom % 16) == 0,
          ($urandom % 64) == 0, ($urandom % 64) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule